// File: doc/BRIEF.md
# Chainable binary counter with gated clear and truncated modulus

This block is a small counter built from two sections that share one clock. The low section is a single toggle stage that divides its count pulses by two. The high section is a binary counter that divides its own count pulses by eight. Used apart, each section counts its own pulse input. When the two sections are chained, the high section advances each time the low stage falls from 1 to 0, and together they form one binary counter over all bits. Ripple clocking is modelled as per-stage advance enables inside a single synchronous clock domain.

The count is cleared only when both clear inputs are high in the same cycle. A single clear input on its own does nothing. In chained operation a mode input selects the modulus: 16, 10 or 12. For the shorter moduli, the first count value past the last wanted state is decoded. That decode drives the same clear path, so the excluded value never reaches the output. A terminal-count flag marks the cycle in which the chained counter is on its last state and is about to wrap.

Top module: `trunc_counter`

## Requirements
- R1: When clr_a and clr_b are both 1 at a rising clock edge, q becomes 0 after that edge. This holds whatever the other inputs are.
- R2: When only one of clr_a or clr_b is 1, the clear has no effect. q advances, or holds, exactly as it would with both clear inputs at 0.
- R3: On each edge with tick_a=1 (and no clear), q[0] inverts. With tick_a=0 it holds.
- R4: When chain=0, q[3:1] counts up by one, modulo 8, on each edge with tick_b=1. It ignores tick_a.
- R5: When chain=1 and mode is 0 or 3, each tick_a moves q through 0 to 15 and then back to 0.
- R6: When chain=1 and mode=1, each tick_a moves q through 0 to 9 and then back to 0. The value 10 never appears.
- R7: When chain=1 and mode=2, each tick_a moves q through 0 to 11 and then back to 0. The value 12 never appears.
- R8: tc is 1 exactly when chain=1, tick_a=1 and q equals the last state of the selected modulus (15, 9 or 11). tc is combinational in the current cycle.
- R9: When chain=1, the high bits advance only when q[0] goes from 1 to 0 on a tick_a. tick_b has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| clr_a | input | 1 | First clear input, effective only together with clr_b |
| clr_b | input | 1 | Second clear input, effective only together with clr_a |
| tick_a | input | 1 | Count pulse for the low toggle stage |
| tick_b | input | 1 | Count pulse for the high section when not chained |
| chain | input | 1 | 1: high section is driven by the low stage's falling output |
| mode | input | 2 | Chained modulus: 0 or 3 = 16, 1 = 10, 2 = 12 |
| q | output | 4 | Count value, bit 0 is the low stage |
| tc | output | 1 | Last state before wrap in chained operation |

## Verification
Every change to q is due one edge after the inputs that cause it. The bench drives inputs on the falling edge, then samples q shortly after the next rising edge. It compares q there against a model that computes the next value arithmetically from the modulus and the clear rule. tc depends only on the present q and inputs, so it is sampled in the same low clock phase in which the inputs are applied, before the edge that would wrap the count.

// File: rtl/trunc_counter.sv
module trunc_counter #(
  parameter int HI_W = 3
) (
  input  logic            clk,
  input  logic            clr_a,
  input  logic            clr_b,
  input  logic            tick_a,
  input  logic            tick_b,
  input  logic            chain,
  input  logic [1:0]      mode,
  output logic [HI_W:0]   q,
  output logic            tc
);
  localparam int W = HI_W + 1;
  localparam logic [W-1:0] DEC_CUT    = W'(10);
  localparam logic [W-1:0] TWELVE_CUT = W'(12);

  logic            both_clr, lo_nxt, hi_en, recycle;
  logic [HI_W-1:0] hi_nxt;
  logic [W-1:0]    cnt_nxt, cut;

  assign both_clr = clr_a & clr_b;
  assign lo_nxt   = q[0] ^ tick_a;
  assign hi_en    = chain ? (tick_a & q[0]) : tick_b;
  assign hi_nxt   = q[W-1:1] + HI_W'(hi_en);
  assign cnt_nxt  = {hi_nxt, lo_nxt};

  always_comb begin
    case (mode)
      2'd1:    cut = DEC_CUT;
      2'd2:    cut = TWELVE_CUT;
      default: cut = '0;
    endcase
  end

  assign recycle = chain & (cnt_nxt == cut);
  assign tc      = chain & tick_a & (q == cut - W'(1));

  always_ff @(posedge clk) begin
    if (both_clr | recycle) q <= '0;
    else                    q <= cnt_nxt;
  end
endmodule

module trunc_counter_chk #(
  parameter int HI_W = 3
) (
  input logic          clk,
  input logic          clr_a,
  input logic          clr_b,
  input logic          tick_a,
  input logic          tick_b,
  input logic          chain,
  input logic [1:0]    mode,
  input logic [HI_W:0] q,
  input logic          tc
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr_a && clr_b) armed <= 1'b1;

  // R1
  clr_both_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_a && clr_b) |=> (q == '0));
  // R3
  lo_toggle_chk: assert property (@(posedge clk) disable iff (!armed)
    (tick_a && !(clr_a && clr_b)) |=> (q[0] != $past(q[0])));
  // R6
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    (chain && mode == 2'd1 && q == 9 && tick_a && !(clr_a && clr_b)) |=> (q == '0));
  // R7
  twelve_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    (chain && mode == 2'd2 && q == 11 && tick_a && !(clr_a && clr_b)) |=> (q == '0));
  // R8
  tc_cond_chk: assert property (@(posedge clk) disable iff (!armed)
    tc |-> (chain && tick_a));
  // R9
  chain_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (chain && !tick_a && !(clr_a && clr_b)) |=> $stable(q));
endmodule

bind trunc_counter trunc_counter_chk #(.HI_W(HI_W)) chk_i (
  .clk(clk), .clr_a(clr_a), .clr_b(clr_b), .tick_a(tick_a), .tick_b(tick_b),
  .chain(chain), .mode(mode), .q(q), .tc(tc)
);

// File: tb/trunc_counter_test.sv
module trunc_counter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic clr_a = 1'b0, clr_b = 1'b0, tick_a = 1'b0, tick_b = 1'b0, chain = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] q;
  logic tc;

  int total = 0, bad = 0;
  int m_q = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trunc_counter uut (.clk(clk), .clr_a(clr_a), .clr_b(clr_b), .tick_a(tick_a),
    .tick_b(tick_b), .chain(chain), .mode(mode), .q(q), .tc(tc));

  function automatic int modulus(input logic [1:0] md);
    return (md == 2'd1) ? 10 : (md == 2'd2) ? 12 : 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic ta, input logic tb,
                      input logic ca, input logic cb);
    int lo, hi, etc;
    @(negedge clk);
    tick_a = ta; tick_b = tb; clr_a = ca; clr_b = cb;
    #1;
    etc = (chain && ta && m_q == modulus(mode) - 1) ? 1 : 0;
    check({req, "/R8 tc"}, int'(tc), etc);
    if (ca && cb) m_q = 0;
    else if (chain) begin
      if (ta) m_q = (m_q + 1) % modulus(mode);
    end else begin
      lo = m_q % 2; hi = m_q / 2;
      if (ta) lo = 1 - lo;
      if (tb) hi = (hi + 1) % 8;
      m_q = hi * 2 + lo;
    end
    @(posedge clk); #1;
    check(req, int'(q), m_q);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step("R1 reset", 0, 0, 1, 1);
    chain = 1'b1;
    mode = 2'd0; for (int i = 0; i < 20; i++) step("R5 mod16", 1, 0, 0, 0);
    step("R1 clear", 0, 0, 1, 1);
    mode = 2'd1; for (int i = 0; i < 25; i++) step("R6 mod10", 1, 0, 0, 0);
    step("R1 clear", 0, 0, 1, 1);
    mode = 2'd2; for (int i = 0; i < 30; i++) step("R7 mod12", 1, 0, 0, 0);
    step("R1 clear", 0, 0, 1, 1);
    mode = 2'd3; for (int i = 0; i < 18; i++) step("R5 mode3", 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R9 tick_b ignored", 0, 1, 0, 0);
    mode = 2'd0;
    step("R2 clr_a only", 1, 0, 1, 0);
    step("R2 clr_b only", 1, 0, 0, 1);
    step("R2 clr_a hold", 0, 0, 1, 0);
    step("R2 clr_b hold", 0, 0, 0, 1);
    step("R1 clear beats tick", 1, 1, 1, 1);
    chain = 1'b0;
    for (int i = 0; i < 5; i++) step("R3 lo toggle", 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) step("R4 hi mod8", 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) step("R4 both ticks", 1, 1, 0, 0);
    step("R3 hold", 0, 0, 0, 0);
    step("R2 unchained clr_a only", 1, 1, 1, 0);
    step("R1 unchained clear", 1, 1, 1, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule